// File: doc/BRIEF.md
# Programmable Periodic Rate and Square-Wave Generator

This block takes a one-cycle enable that fires at 32.768 kHz and divides it down to a periodic event. A four-bit rate code picks which power-of-two stage of the divider chain is used. The same stage drives a square-wave output with a 50 percent duty cycle and a one-cycle periodic strobe. A later stage, outside this block, latches the strobe as an interrupt flag.

The divider runs only while the two-bit time-base select holds the one supported code, binary 01. Any other code holds the chain at zero. A separate enable gates the square-wave pin, and the strobe does not depend on that enable. All pins are plain control and status signals. No data flows through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `prg_rate_wave`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset is released, `sqw_out` and `pf_pulse` are 0 and the divider count is zero.
- R2: The divider counts only while `div_sel` equals binary 01. For any other code the count is held at zero, no strobe fires and `sqw_out` stays 0. When the code returns to 01, counting starts again from zero.
- R3: For rate codes 3 to 15, the square-wave period is 2^(code-1) time-base ticks, which is 32768 >> (code-1) Hz. Code 0110 gives 1.024 kHz: a 32-tick period and a strobe every 976.562 us.
- R4: Rate code 1 gives a 128-tick period (256 Hz). Rate code 2 gives a 256-tick period (128 Hz).
- R5: Rate code 0 produces no square wave (output 0) and no strobe.
- R6: The wave is low for the first half of each period and high for the second half, counted in ticks from the divider's zero point.
- R7: `pf_pulse` is high for exactly one clock cycle, once per period. That cycle is the one in which the square wave rises.
- R8: With `sqw_en` at 0, `sqw_out` is 0. `pf_pulse` keeps running unchanged.
- R9: The divider advances only on clock cycles with `tbase_tick` high. Cycles without a tick change no output.
- R10: A change of rate code takes effect in the same cycle. The output follows the new stage of the running divider, and the divider does not restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbase_tick | input | 1 | One-cycle pulse at the 32.768 kHz time-base rate |
| rate_sel | input | 4 | Rate code choosing the divider stage |
| div_sel | input | 2 | Time-base select; the divider runs only at binary 01 |
| sqw_en | input | 1 | Square-wave output enable |
| sqw_out | output | 1 | Square wave, gated by `sqw_en` |
| pf_pulse | output | 1 | One-cycle periodic strobe at each rising edge of the wave |

## Verification
The slowest rates are the hardest to reach from the ports. Rate code 15 needs 16384 ticks for one period, and a wrap of the divider needs a full count. The stimulus fires the tick on every clock cycle, so every code from 3 to 15 runs through two full periods within the cycle budget. Other phases use sparse ticks, switch the rate mid-period, and cycle `div_sel` through each invalid code. A behavioural tick-count model is compared with both outputs on every clock.

// File: rtl/prg_pkg.sv
package prg_pkg;
  localparam int unsigned RATE_W  = 4;
  localparam int unsigned DSEL_W  = 2;
  localparam int unsigned CNT_W   = 14;
  localparam int unsigned IDX_W   = $clog2(CNT_W);
  localparam logic [DSEL_W-1:0] DSEL_RUN = 2'b01;
  // half-period bit index for the two low-rate codes
  localparam logic [IDX_W-1:0] LOW1_IDX = IDX_W'(6);
  localparam logic [IDX_W-1:0] LOW2_IDX = IDX_W'(7);

  typedef struct packed {
    logic             en;
    logic [IDX_W-1:0] idx;
  } tap_t;
endpackage

// File: rtl/prg_rate_decode.sv
module prg_rate_decode
  import prg_pkg::*;
(
  input  logic [RATE_W-1:0] rate_sel,
  output tap_t              tap
);
  // idx is the bit of the counter that is high in the second half of a period
  always_comb begin
    tap.en  = 1'b1;
    tap.idx = '0;
    case (rate_sel)
      RATE_W'(0): tap.en  = 1'b0;
      RATE_W'(1): tap.idx = LOW1_IDX;
      RATE_W'(2): tap.idx = LOW2_IDX;
      default:    tap.idx = IDX_W'(rate_sel - RATE_W'(2));
    endcase
  end
endmodule

// File: rtl/prg_div_chain.sv
module prg_div_chain
  import prg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             adv
);
  assign adv = run & tick;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= cnt + CNT_W'(1);
  end

  AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt)); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick) |=> (cnt == $past(cnt) + CNT_W'(1))); // R9
endmodule

// File: rtl/prg_wave_gen.sv
module prg_wave_gen
  import prg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             adv,
  input  tap_t             tap,
  input  logic             sqw_en,
  output logic             sqw_out,
  output logic             pf_pulse
);
  logic [CNT_W-1:0] low_mask;
  logic             tap_bit;
  logic             wave_raw;
  logic             at_rise;

  assign low_mask = (CNT_W'(1) << tap.idx) - CNT_W'(1);
  assign tap_bit  = cnt[tap.idx];
  assign wave_raw = tap.en & tap_bit;
  // the next tick carries the low bits over into the tap bit
  assign at_rise  = tap.en & adv & ~tap_bit & ((cnt & low_mask) == low_mask);
  assign sqw_out  = sqw_en & wave_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) pf_pulse <= 1'b0;
    else        pf_pulse <= at_rise;
  end

  AST_PF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_pulse |=> !pf_pulse); // R7
  AST_PF_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    pf_pulse |-> $past(adv)); // R9
  AST_PF_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_pulse && ($past(tap) == tap)) |-> wave_raw); // R7
  AST_TAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tap.en |-> (32'(tap.idx) < CNT_W)); // R3
endmodule

// File: rtl/prg_rate_wave.sv
module prg_rate_wave
  import prg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbase_tick,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [DSEL_W-1:0] div_sel,
  input  logic              sqw_en,
  output logic              sqw_out,
  output logic              pf_pulse
);
  tap_t             tap;
  logic             run;
  logic             adv;
  logic [CNT_W-1:0] cnt;

  assign run = (div_sel == DSEL_RUN);

  prg_rate_decode u_decode (
    .rate_sel (rate_sel),
    .tap      (tap)
  );

  prg_div_chain u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tbase_tick),
    .cnt   (cnt),
    .adv   (adv)
  );

  prg_wave_gen u_wave (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (cnt),
    .adv      (adv),
    .tap      (tap),
    .sqw_en   (sqw_en),
    .sqw_out  (sqw_out),
    .pf_pulse (pf_pulse)
  );

  AST_RATE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(rate_sel) == '0) && (rate_sel == '0)) |-> (!pf_pulse && !sqw_out)); // R5
  AST_BAD_DSEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run) && !run) |-> (!pf_pulse && !sqw_out)); // R2
endmodule

// File: tb/prg_rate_wave_bench.sv
module prg_rate_wave_bench;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tbase_tick = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic [1:0] div_sel = 2'b00;
  logic       sqw_en = 1'b0;
  logic       sqw_out;
  logic       pf_pulse;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string tag = "R1";

  int m_cnt = 0;
  bit m_pf = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  prg_rate_wave u_prg_rate_wave (
    .clk        (clk),
    .rst_n      (rst_n),
    .tbase_tick (tbase_tick),
    .rate_sel   (rate_sel),
    .div_sel    (div_sel),
    .sqw_en     (sqw_en),
    .sqw_out    (sqw_out),
    .pf_pulse   (pf_pulse)
  );

  // period in ticks from the rate code (R3, R4, R5)
  function automatic int per_of(logic [3:0] c);
    if (c == 4'd0) return 0;
    if (c == 4'd1) return 128;
    if (c == 4'd2) return 256;
    return 1 << (int'(c) - 1);
  endfunction

  // reference model: ticks since the divider's zero point
  always @(posedge clk) begin
    int p;
    bit run;
    if (!rst_n) begin
      m_cnt = 0;
      m_pf  = 1'b0;
    end else begin
      p    = per_of(rate_sel);
      run  = (div_sel == 2'b01);
      m_pf = run && tbase_tick && (p != 0) && (((m_cnt + 1) % p) == p / 2);
      if (!run)           m_cnt = 0;
      else if (tbase_tick) m_cnt = (m_cnt + 1) % 16384;
    end
  end

  task automatic chk(string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int  p;
    bit  e_sqw;
    p     = per_of(rate_sel);
    e_sqw = rst_n && sqw_en && (p != 0) && ((m_cnt % p) >= p / 2);
    chk("sqw_out", sqw_out, e_sqw);
    chk("pf_pulse", pf_pulse, m_pf);
  endtask

  task automatic run_cycles(int n, int every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      tbase_tick = (every > 0) && ((i % every) == 0);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_NS * 180000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired during %s", tag);
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tag = "R1";
    div_sel = 2'b01; rate_sel = 4'd6; sqw_en = 1'b1; tbase_tick = 1'b1;
    run_cycles(4, 1);
    rst_n = 1'b1;
    tbase_tick = 1'b0;
    @(negedge clk);
    chk("sqw_out after reset", sqw_out, 1'b0);
    chk("pf_pulse after reset", pf_pulse, 1'b0);

    // R3 / R6 / R7: 1.024 kHz stage, a tick every cycle
    tag = "R3"; run_cycles(100, 1);
    tag = "R6"; run_cycles(70, 1);
    tag = "R7"; rate_sel = 4'd3; run_cycles(40, 1);

    // R9: sparse ticks
    tag = "R9"; run_cycles(90, 3);
    run_cycles(60, 0);
    run_cycles(80, 5);

    // R4: low-rate codes
    tag = "R4"; rate_sel = 4'd1; run_cycles(300, 1);
    rate_sel = 4'd2; run_cycles(600, 1);

    // R5: code zero
    tag = "R5"; rate_sel = 4'd0; run_cycles(200, 1);

    // R8: output gated, strobe kept
    tag = "R8"; rate_sel = 4'd4; sqw_en = 1'b0; run_cycles(60, 1);
    sqw_en = 1'b1; run_cycles(20, 1);

    // R2: invalid time-base codes hold the chain
    tag = "R2";
    for (int d = 0; d < 4; d++) begin
      div_sel = 2'(d);
      run_cycles(37, 1);
    end
    div_sel = 2'b01; run_cycles(40, 1);

    // R10: rate switch mid-period
    tag = "R10";
    rate_sel = 4'd5; run_cycles(13, 1);
    rate_sel = 4'd3; run_cycles(7, 1);
    rate_sel = 4'd7; run_cycles(45, 1);
    rate_sel = 4'd4; run_cycles(11, 2);

    // R3: every code 3..15, two full periods each
    tag = "R3";
    for (int c = 3; c <= 15; c++) begin
      rate_sel = 4'(c);
      div_sel = 2'b00; run_cycles(2, 1);
      div_sel = 2'b01; run_cycles(2 * per_of(4'(c)) + 6, 1);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule